// File: doc/BRIEF.md
# Auxiliary packet RAM controller

This block holds the small auxiliary packets (infoframes) that a display transmitter sends during blanking. A host fills each packet slot through a 32-bit register bus. Every slot owns a window of nine words. Seven packet bytes are packed into each pair of words. The host switches a slot on or off with one bit in a configuration register. A global bit in the same register gates the whole packet store.

When the host turns a slot on, the block copies that slot's staged words into a shadow memory. The transmit side reads packet bytes from the shadow memory through a per-slot byte port. A slot's status bit changes only at a packet boundary, which is marked by a one-cycle frame tick. The status bit rises at the first tick after the copy has finished. It falls at the first tick after the slot, or the whole store, has been switched off. The host polls the status register to see both transitions. A packet type code t (0x80 and up) uses slot t − 0x80.

Top module: `pkt_ram_ctrl`

## Requirements
- R1: Slot n's window starts at byte offset 0x400 + n·0x24. Word w of the slot is at window + 4·w, with nine words per slot. A packet of type code t is stored in slot t − 0x80. Only word-aligned offsets inside the windows reach the staging store.
- R2: Packet byte b of a slot sits in word 2·(b div 7) + (b mod 7 ≥ 3 ? 1 : 0). Its byte lane is b mod 7 for b mod 7 < 3, and (b mod 7) − 3 otherwise (lane k is bits 8k+7:8k). Lane 3 of the even words is unused. Byte b of slot s appears on `ser_data` one cycle after `ser_slot`=s and `ser_byte`=b are presented, with b ranging from 0 to 30.
- R3: The configuration register sits at 0x0A0. Bit 16 is the global RAM enable and bit n is the enable of slot n. All other bits read zero. The data of a read appears on `bus_rdata` in the cycle after `bus_rd`, and reads as zero when no read was made.
- R4: The status register sits at 0x0A4 and reads `slot_active` in bits n. Writes to it have no effect.
- R5: `slot_active` changes only in the cycle after `frame_tick` was high. At a tick, bit n becomes 1 if slot n is enabled, the RAM is enabled and the slot's copy has finished. Otherwise bit n becomes 0. A disabled slot therefore drops at the first tick after its enable is cleared.
- R6: While bit 16 of the configuration is 0, no `slot_active` bit becomes set.
- R7: Writing zero to the configuration register reads back as zero and clears every `slot_active` bit at the next tick.
- R8: The transmitted copy of a slot is its staged content at the moment its enable rose. Later window writes to a transmitting slot do not change `ser_data`.
- R9: Reads of undecoded or misaligned offsets return zero. Writes to them change neither the configuration, the status nor any slot's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| frame_tick | input | 1 | Packet-boundary pulse from the scheduler |
| ser_slot | input | 3 | Slot selected by the serializer |
| ser_byte | input | 5 | Packet byte index selected by the serializer |
| ser_data | output | 8 | Selected shadow byte, one cycle later |
| slot_active | output | 8 | Per-slot transmit status |

## Verification
A window write to a transmitting slot can land in the same cycle as a serializer read of that slot. The bench overwrites an active slot's staging words with fresh random bytes and then reads every byte of the slot through the serializer port. It judges the output against the bench's model of the shadow copy, which was captured when the slot's enable rose. A second collision is between a configuration write and a frame tick while a copy is pending. It is provoked by toggling slot enables under a disabled RAM and then enabling the RAM. The status reported after the following tick is compared with the model.

// File: rtl/pkt_ram_pkg.sv
package pkt_ram_pkg;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_RUN  = 2'd1,
    CP_DONE = 2'd2
  } cp_state_e;

  // Word within a slot that carries packet byte b (seven bytes per word pair)
  function automatic int pkt_byte_word(input int b);
    return 2 * (b / 7) + (((b % 7) >= 3) ? 1 : 0);
  endfunction

  // Byte lane inside that word
  function automatic int pkt_byte_lane(input int b);
    return ((b % 7) >= 3) ? (b % 7) - 3 : (b % 7);
  endfunction

endpackage

// File: rtl/pkt_ram_sdp.sv
module pkt_ram_sdp #(
  parameter int DEPTH = 72,
  parameter int AW    = 7,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/pkt_bus_regs.sv
module pkt_bus_regs #(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 9,
  parameter int ADDR_W     = 12,
  parameter int MEM_AW     = 7,
  parameter int RAM_EN_BIT = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0A0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0A4,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 'h400
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_SLOTS-1:0] status,
  output logic [NUM_SLOTS-1:0] cfg_slots,
  output logic                 ram_en,
  output logic [NUM_SLOTS-1:0] cfg_rise,
  output logic [NUM_SLOTS-1:0] cfg_fall,
  output logic                 stg_we,
  output logic [MEM_AW-1:0]    stg_waddr
);

  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(SLOT_WORDS * 4);
  localparam logic [ADDR_W-1:0] SPAN_A   = ADDR_W'(NUM_SLOTS * SLOT_WORDS * 4);
  localparam logic [ADDR_W-1:0] WORDS_A  = ADDR_W'(SLOT_WORDS);

  logic [ADDR_W-1:0] win_off;
  logic [ADDR_W-1:0] win_slot;
  logic [ADDR_W-1:0] win_word;
  logic              in_win;
  logic              cfg_hit;
  logic [31:0]       rd_val;

  always_comb begin
    win_off  = bus_addr - WIN_BASE;
    in_win   = (bus_addr >= WIN_BASE) && (win_off < SPAN_A) && (bus_addr[1:0] == 2'b00);
    win_slot = win_off / STRIDE_A;
    win_word = (win_off % STRIDE_A) >> 2;
    stg_we    = bus_wr && in_win;
    stg_waddr = MEM_AW'(win_slot * WORDS_A + win_word);
    cfg_hit   = bus_wr && (bus_addr == CFG_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_slots <= '0;
      ram_en    <= 1'b0;
      cfg_rise  <= '0;
      cfg_fall  <= '0;
    end else begin
      cfg_rise <= '0;
      cfg_fall <= '0;
      if (cfg_hit) begin
        cfg_slots <= bus_wdata[NUM_SLOTS-1:0];
        ram_en    <= bus_wdata[RAM_EN_BIT];
        cfg_rise  <= bus_wdata[NUM_SLOTS-1:0] & ~cfg_slots;
        cfg_fall  <= ~bus_wdata[NUM_SLOTS-1:0] & cfg_slots;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == CFG_ADDR) begin
      rd_val[NUM_SLOTS-1:0] = cfg_slots;
      rd_val[RAM_EN_BIT]    = ram_en;
    end else if (bus_addr == STAT_ADDR) begin
      rd_val[NUM_SLOTS-1:0] = status;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/pkt_copy_engine.sv
module pkt_copy_engine
  import pkt_ram_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 9,
  parameter int MEM_AW     = 7,
  parameter int SLOT_W     = 3,
  parameter int WIDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] cfg_slots,
  input  logic                 ram_en,
  input  logic [NUM_SLOTS-1:0] cfg_rise,
  input  logic [NUM_SLOTS-1:0] cfg_fall,
  input  logic                 frame_tick,
  output logic                 stg_re,
  output logic [MEM_AW-1:0]    stg_raddr,
  output logic                 shd_we,
  output logic [MEM_AW-1:0]    shd_waddr,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic [NUM_SLOTS-1:0] status
);

  cp_state_e             state;
  logic [WIDX_W-1:0]     rd_idx;
  logic [NUM_SLOTS-1:0]  pending;
  logic [NUM_SLOTS-1:0]  ready;
  logic [NUM_SLOTS-1:0]  cand;
  logic [NUM_SLOTS-1:0]  done_mask;
  logic [SLOT_W-1:0]     pick;
  logic                  cand_any;

  always_comb begin
    cand     = pending & ~status;
    pick     = '0;
    cand_any = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick     = SLOT_W'(i);
        cand_any = 1'b1;
      end
    end
    done_mask = '0;
    if (state == CP_DONE) done_mask[cur_slot] = 1'b1;
    stg_re    = (state == CP_RUN);
    stg_raddr = MEM_AW'(int'(cur_slot) * SLOT_WORDS + int'(rd_idx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CP_IDLE;
      rd_idx    <= '0;
      cur_slot  <= '0;
      pending   <= '0;
      ready     <= '0;
      status    <= '0;
      shd_we    <= 1'b0;
      shd_waddr <= '0;
    end else begin
      shd_we    <= stg_re;
      shd_waddr <= stg_raddr;
      pending   <= (pending & ~done_mask & ~cfg_fall) | cfg_rise;
      ready     <= (ready | done_mask) & ~cfg_rise;
      if (frame_tick)
        status <= cfg_slots & {NUM_SLOTS{ram_en}} & ready & ~pending & ~cfg_rise;
      case (state)
        CP_IDLE: if (cand_any) begin
          cur_slot <= pick;
          rd_idx   <= '0;
          state    <= CP_RUN;
        end
        CP_RUN: begin
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == WIDX_W'(SLOT_WORDS - 1)) state <= CP_DONE;
        end
        default: state <= CP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_ram_ctrl.sv
module pkt_ram_ctrl
  import pkt_ram_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 9,
  parameter int ADDR_W     = 12,
  parameter int RAM_EN_BIT = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0A0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0A4,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 'h400,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int PKT_BYTES = (SLOT_WORDS / 2) * 7 + (SLOT_WORDS % 2) * 3,
  localparam int BYTE_W    = $clog2(PKT_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 frame_tick,
  input  logic [SLOT_W-1:0]    ser_slot,
  input  logic [BYTE_W-1:0]    ser_byte,
  output logic [7:0]           ser_data,
  output logic [NUM_SLOTS-1:0] slot_active
);

  localparam int MEM_DEPTH = NUM_SLOTS * SLOT_WORDS;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int WIDX_W    = $clog2(SLOT_WORDS);

  logic [NUM_SLOTS-1:0] cfg_slots, cfg_rise, cfg_fall;
  logic                 ram_en;
  logic                 stg_we, stg_re, shd_we;
  logic [MEM_AW-1:0]    stg_waddr, stg_raddr, shd_waddr, shd_raddr;
  logic [31:0]          stg_q, shd_q;
  logic [SLOT_W-1:0]    cur_slot;
  logic [1:0]           lane_n, lane_q;

  pkt_bus_regs #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .ADDR_W(ADDR_W),
    .MEM_AW(MEM_AW), .RAM_EN_BIT(RAM_EN_BIT),
    .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR), .WIN_BASE(WIN_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status(slot_active), .cfg_slots(cfg_slots), .ram_en(ram_en),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .stg_we(stg_we), .stg_waddr(stg_waddr)
  );

  pkt_ram_sdp #(.DEPTH(MEM_DEPTH), .AW(MEM_AW), .DW(32)) u_stage (
    .clk(clk), .we(stg_we), .waddr(stg_waddr), .wdata(bus_wdata),
    .re(stg_re), .raddr(stg_raddr), .rdata(stg_q)
  );

  pkt_copy_engine #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .MEM_AW(MEM_AW),
    .SLOT_W(SLOT_W), .WIDX_W(WIDX_W)
  ) u_copy (
    .clk(clk), .rst(rst), .cfg_slots(cfg_slots), .ram_en(ram_en),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .frame_tick(frame_tick),
    .stg_re(stg_re), .stg_raddr(stg_raddr), .shd_we(shd_we),
    .shd_waddr(shd_waddr), .cur_slot(cur_slot), .status(slot_active)
  );

  always_comb begin
    shd_raddr = MEM_AW'(int'(ser_slot) * SLOT_WORDS + pkt_byte_word(int'(ser_byte)));
    lane_n    = 2'(pkt_byte_lane(int'(ser_byte)));
  end

  pkt_ram_sdp #(.DEPTH(MEM_DEPTH), .AW(MEM_AW), .DW(32)) u_shadow (
    .clk(clk), .we(shd_we), .waddr(shd_waddr), .wdata(stg_q),
    .re(1'b1), .raddr(shd_raddr), .rdata(shd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else     lane_q <= lane_n;
  end

  assign ser_data = shd_q[8*lane_q +: 8];

endmodule

// File: rtl/pkt_ram_ctrl_chk.sv
module pkt_ram_ctrl_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 12,
  parameter int SLOT_W    = 3,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0A0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0A4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_tick,
  input logic [NUM_SLOTS-1:0] slot_active,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 ram_en,
  input logic                 shd_we,
  input logic [SLOT_W-1:0]    cur_slot
);

  assert_status_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(slot_active));

  assert_no_set_while_off_R6: assert property (@(posedge clk) disable iff (rst)
    !ram_en |=> ((slot_active & ~$past(slot_active)) == '0));

  assert_shadow_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    shd_we |-> !slot_active[cur_slot]);

  assert_status_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == STAT_ADDR) |=> (bus_rdata == 32'($past(slot_active))));

  assert_low_offsets_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr < CFG_ADDR) |=> (bus_rdata == '0));

endmodule

bind pkt_ram_ctrl pkt_ram_ctrl_chk #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
  .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .slot_active(slot_active),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ram_en(ram_en), .shd_we(shd_we), .cur_slot(cur_slot)
);

// File: tb/pkt_ram_ctrl_bench.sv
module pkt_ram_ctrl_bench;
  localparam int NS = 8;
  localparam int SW = 9;
  localparam int PB = 31;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, bus_wr, bus_rd, frame_tick;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  ser_slot;
  logic [4:0]  ser_byte;
  logic [7:0]  ser_data;
  logic [NS-1:0] slot_active;

  pkt_ram_ctrl u_pkt_ram_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_tick(frame_tick), .ser_slot(ser_slot), .ser_byte(ser_byte),
    .ser_data(ser_data), .slot_active(slot_active)
  );

  logic [7:0]    stg_m [NS][PB];
  logic [7:0]    shd_m [NS][PB];
  logic [NS-1:0] cfg_m, st_m;
  logic          en_m;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] win_addr(input int s, input int w);
    return 12'(32'h400 + s * 32'h24 + 4 * w);
  endfunction

  function automatic logic [31:0] cfg_exp();
    return (32'(en_m) << 16) | 32'(cfg_m);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ser_rd(input int s, input int b, output logic [7:0] d);
    @(negedge clk); ser_slot = 3'(s); ser_byte = 5'(b);
    @(negedge clk); d = ser_data;
  endtask

  task automatic set_cfg(input logic [31:0] v);
    for (int s = 0; s < NS; s++)
      if (v[s] && !cfg_m[s])
        for (int b = 0; b < PB; b++) shd_m[s][b] = stg_m[s][b];
    cfg_m = v[NS-1:0];
    en_m  = v[16];
    wr(12'h0A0, v);
  endtask

  task automatic tick();
    repeat (120) @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    st_m = en_m ? cfg_m : '0;
  endtask

  // Packed word w of slot s from the model; the unused lane gets noise
  function automatic logic [31:0] pack_word(input int s, input int w);
    int g = w / 2;
    if (w % 2 == 0)
      return {8'($urandom), stg_m[s][7*g+2], stg_m[s][7*g+1], stg_m[s][7*g]};
    return {stg_m[s][7*g+6], stg_m[s][7*g+5], stg_m[s][7*g+4], stg_m[s][7*g+3]};
  endfunction

  task automatic fill_slot(input int s);
    for (int b = 0; b < PB; b++) stg_m[s][b] = 8'($urandom);
    for (int w = 0; w < SW; w++) wr(win_addr(s, w), pack_word(s, w));
  endtask

  task automatic check_slot(input string req, input int s);
    logic [7:0] d;
    for (int b = 0; b < PB; b++) begin
      ser_rd(s, b, d);
      chk(req, 32'(d), 32'(shd_m[s][b]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [11:0] bad_list [8];
    void'($urandom(32'd7741));
    bad_list = '{12'h000, 12'h09C, 12'h0A8, 12'h3FC, 12'h401, 12'h520, 12'h7FC, 12'hFFC};
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    frame_tick = 0; ser_slot = '0; ser_byte = '0;
    cfg_m = '0; en_m = 0; st_m = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state (R3, R4)
    chk("R4 reset slot_active", 32'(slot_active), 32'h0);
    rd(12'h0A0, d); chk("R3 reset cfg", d, 32'h0);
    rd(12'h0A4, d); chk("R4 reset status", d, 32'h0);

    // Config readback: unused bits read zero (R3)
    set_cfg(32'h0001_0000);
    rd(12'h0A0, d); chk("R3 ram enable readback", d, 32'h0001_0000);
    wr(12'h0A0, 32'hFFFF_FFFF);
    rd(12'h0A0, d); chk("R3 only defined bits", d, 32'h0001_00FF);
    wr(12'h0A0, 32'h0001_0000);

    // Fill all slots (R1)
    for (int s = 0; s < NS; s++) fill_slot(s);

    // Type 0x82 uses slot 2 (R1, R2, R5)
    set_cfg(32'h0001_0004);
    repeat (30) @(negedge clk);
    chk("R5 no rise before tick", 32'(slot_active), 32'(st_m));
    tick();
    chk("R5 rise at tick", 32'(slot_active), 32'(st_m));
    rd(12'h0A4, d); chk("R4 status mirrors", d, 32'(st_m));
    check_slot("R1 R2 slot 2 bytes", 2);

    // Overwrite an active slot's staging (R8)
    fill_slot(2);
    check_slot("R8 active slot unchanged", 2);

    // Disable then re-enable with new content (R5)
    set_cfg(32'h0001_0000);
    repeat (10) @(negedge clk);
    chk("R5 holds until tick", 32'(slot_active), 32'h04);
    tick();
    chk("R5 drop at tick", 32'(slot_active), 32'(st_m));
    set_cfg(32'h0001_0004);
    tick();
    chk("R5 re-rise", 32'(slot_active), 32'(st_m));
    check_slot("R8 new copy after re-enable", 2);

    // Random rounds over slots (R1, R2, R5)
    for (int r = 0; r < 6; r++) begin
      int s = $urandom_range(0, NS - 1);
      set_cfg(cfg_exp() & ~(32'h1 << s));
      tick();
      chk("R5 random disable", 32'(slot_active), 32'(st_m));
      fill_slot(s);
      set_cfg(cfg_exp() | (32'h1 << s));
      tick();
      chk("R5 random enable", 32'(slot_active), 32'(st_m));
      check_slot("R2 random slot bytes", s);
    end

    // Status is read-only (R4)
    wr(12'h0A4, 32'h0000_00FF);
    rd(12'h0A4, d); chk("R4 write ignored", d, 32'(st_m));
    rd(12'h0A0, d); chk("R4 cfg untouched", d, cfg_exp());

    // Undecoded and misaligned accesses (R9)
    for (int k = 0; k < 20; k++) begin
      logic [11:0] a = bad_list[$urandom_range(0, 7)];
      wr(a, $urandom);
      rd(a, d); chk("R9 undecoded reads zero", d, 32'h0);
    end
    rd(12'h0A0, d); chk("R9 cfg unchanged", d, cfg_exp());
    tick();
    chk("R9 status unchanged", 32'(slot_active), 32'(st_m));
    check_slot("R9 slot 2 unchanged", 2);

    // RAM disabled blocks every rise (R6)
    set_cfg(32'h0000_00FF);
    tick();
    chk("R6 no status with ram off", 32'(slot_active), 32'h0);
    set_cfg(32'h0001_00FF);
    tick();
    chk("R6 status after ram on", 32'(slot_active), 32'(st_m));

    // Clear everything (R7)
    set_cfg(32'h0);
    rd(12'h0A0, d); chk("R7 cfg reads zero", d, 32'h0);
    tick();
    chk("R7 all status drop", 32'(slot_active), 32'h0);

    finish_run();
  end

endmodule